// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the issue stage of an in-order processor that can start two instructions per cycle. Each cycle it looks at the two oldest pre-decoded instructions, called slot A (older) and slot B (younger). It decides whether both may go down the pipeline together. The decision depends on the order-sensitive compatibility of their instruction classes. It also depends on a set of operand, condition-bit and control-flow exceptions, and on the fact that only one of the two integer ALUs can execute shifts, memory operations and tests.

When the block answers "bundle", both instructions issue. When it answers "no bundle", only slot A issues, and the surrounding sequencer moves slot B into slot A for the next cycle. That sequencer is outside this block.

The block also produces a steering bit that tells the execution stage which slot owns the capable ALU. Both results are registered, so they apply to the instructions presented one clock edge earlier.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `bundle_o` and `steer_o` are cleared to 0 at that edge, whatever the inputs are.
- R2: `bundle_o` and `steer_o` change only on a rising clock edge. They reflect the inputs sampled at that edge, with a latency of exactly one edge.
- R3: The class codes are: 0 FP arithmetic, 1 memory load/store, 2 integer ALU, 3 shift/extract/deposit, 4 may-nullify-next, 5 indirect/external branch, 6 other branch, 7 FP test/status, 8 system control; codes 9 to 15 never bundle. The allowed A→B pairs are:
  - A=0 followed by B in {1,2,3,4,5,6}
  - A=1 followed by B in {0,2,3,4,6}
  - A=2 followed by B in {0,1,2,3,4,6,7}
  - A=3 followed by B in {0,1,2,7}
  - A=4 followed by B=0
  - every other ordered pair is refused.
- R4: A system control instruction (class 8) in either slot never bundles.
- R5: No bundle is given unless both `a_vld` and `b_vld` are 1.
- R6: Read-after-write dependency:
  - The pair is refused when A writes a register (`a_rdv`) that B reads through rs1 (`b_rv[0]`) or rs2 (`b_rv[1]`), with both instructions in the same register file.
  - The register file is FP when flag bit 0 is 1, integer when it is 0.
  - Exception: an FP arithmetic A followed by an FP store is allowed. The FP store is class 1 with flag bits 0 and 1 set.
- R7: FP load against FP arithmetic, in either order:
  - An FP load is class 1 with flag bit 0 set, flag bit 1 clear and `rdv` set. An FP arithmetic op is class 0 with flag bit 0 set.
  - The pair is refused when both write the same target register.
  - The pair is also refused when the load writes a single word (flag bit 2 = 1, word select in flag bit 3) and the arithmetic op names that register while using the whole doubleword (its flag bit 2 = 0) or the other word.
- R8: The pair is refused when either instruction may set the carry/borrow bits (flag bit 4) and the other consumes them (flag bit 5).
- R9: The pair is refused when A is in a branch delay slot (`a_dly`). It is also refused when A is a taken-branch target (`a_tgt`) at an odd word address (`a_waddr_lo` = 1). A taken-branch target at an even word address is not restricted.
- R10: When A may nullify its successor (flag bit 6), the pair is allowed only if B is class 0.
- R11: Capable-ALU and load/store pairing limits:
  - An instruction needs the capable ALU when it is class 3, class 4, or class 1 with flag bit 0 clear.
  - Two instructions that both need the capable ALU never bundle.
  - Two class 1 instructions never bundle.
- R12: `steer_o` is 1 exactly when the pair bundles and B needs the capable ALU; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_vld | input | 1 | Slot A holds an instruction |
| a_cls | input | 4 | Slot A class code |
| a_rs1 | input | RW | Slot A first source register |
| a_rs2 | input | RW | Slot A second source register |
| a_rd | input | RW | Slot A destination register |
| a_rv | input | 2 | Slot A source-read valids (bit 0 rs1, bit 1 rs2) |
| a_rdv | input | 1 | Slot A writes `a_rd` |
| a_flags | input | 7 | Slot A flags: 0 FP regs, 1 store, 2 single word, 3 high word, 4 sets carry, 5 uses carry, 6 may nullify |
| a_dly | input | 1 | Slot A is in a branch delay slot |
| a_tgt | input | 1 | Slot A is the target of a taken branch |
| a_waddr_lo | input | 1 | Low bit of slot A word address |
| b_vld | input | 1 | Slot B holds an instruction |
| b_cls | input | 4 | Slot B class code |
| b_rs1 | input | RW | Slot B first source register |
| b_rs2 | input | RW | Slot B second source register |
| b_rd | input | RW | Slot B destination register |
| b_rv | input | 2 | Slot B source-read valids |
| b_rdv | input | 1 | Slot B writes `b_rd` |
| b_flags | input | 7 | Slot B flags, same layout as `a_flags` |
| bundle_o | output | 1 | Registered: both slots issue together |
| steer_o | output | 1 | Registered: slot B owns the capable ALU |

## Verification
Every result of this block is due one rising edge after the pair that produced it was presented. There is no other latency.

The bench therefore drives a new pair just after each falling edge. At the next falling edge it compares `bundle_o` and `steer_o` with the expectation it computed for the pair driven one cycle before, and only then drives the next pair. This gives one comparison per clock, half a period away from the capturing edge.

During reset the expectation is the cleared state, regardless of the pair held on the inputs.

// File: rtl/pair_pkg.sv
// Package: shared class codes, flag layout and compatibility rules for the
// dual-issue pairing checker. Assumes class codes fit in CLS_W bits.
package pair_pkg;

    localparam int CLS_W = 4;
    localparam int FLAG_W = 7;

    typedef enum logic [CLS_W-1:0] {
        CL_FLOP = 4'd0,
        CL_LDST = 4'd1,
        CL_FLEX = 4'd2,
        CL_MM   = 4'd3,
        CL_NUL  = 4'd4,
        CL_BV   = 4'd5,
        CL_BR   = 4'd6,
        CL_FSYS = 4'd7,
        CL_SYS  = 4'd8
    } iclass_e;

    // Packed so that fp lands in bit 0 and nul in bit 6.
    typedef struct packed {
        logic nul;
        logic cuse;
        logic cset;
        logic whi;
        logic wsingle;
        logic store;
        logic fp;
    } iflags_t;

    // Bit s of the result is set when class s may follow class f in one bundle.
    function automatic logic [2**CLS_W-1:0] follow_mask(input iclass_e f);
        logic [2**CLS_W-1:0] m;
        m = '0;
        case (f)
            CL_FLOP: m[8:0] = 9'b0_0111_1110;
            CL_LDST: m[8:0] = 9'b0_0101_1101;
            CL_FLEX: m[8:0] = 9'b0_1101_1111;
            CL_MM:   m[8:0] = 9'b0_1000_0111;
            CL_NUL:  m[8:0] = 9'b0_0000_0001;
            default: m = '0;
        endcase
        return m;
    endfunction

    // True when the instruction can only run on the shift/memory/test ALU.
    function automatic logic needs_cap(input iclass_e c, input iflags_t f);
        return (c == CL_MM) || (c == CL_NUL) || (c == CL_LDST && !f.fp);
    endfunction

endpackage

// File: rtl/pair_class_matrix.sv
// Module: pair_class_matrix
// Decides class-level compatibility of an ordered pair: the follow matrix,
// the nullify-successor limit, the single capable ALU and the load/store pair
// limit. Purely combinational. Assumes slot A is the older instruction.
module pair_class_matrix
    import pair_pkg::*;
(
    input  iclass_e cls_a,
    input  iclass_e cls_b,
    input  iflags_t fl_a,
    input  iflags_t fl_b,
    output logic    class_ok,
    output logic    cap_b
);

    logic [2**CLS_W-1:0] mask_a;
    logic                matrix_ok;
    logic                nul_ok;
    logic                cap_clash;
    logic                mem_pair;

    // Look up which classes may follow A and test B against that row.
    always_comb begin
        mask_a    = follow_mask(cls_a);
        matrix_ok = mask_a[cls_b];
    end

    // Apply the successor-nullify limit and the shared-resource limits.
    always_comb begin
        nul_ok    = !fl_a.nul || (cls_b == CL_FLOP);
        cap_b     = needs_cap(cls_b, fl_b);
        cap_clash = needs_cap(cls_a, fl_a) && cap_b;
        mem_pair  = (cls_a == CL_LDST) && (cls_b == CL_LDST);
        class_ok  = matrix_ok && nul_ok && !cap_clash && !mem_pair;
    end

endmodule

// File: rtl/pair_hazard_check.sv
// Module: pair_hazard_check
// Flags operand and condition-bit hazards that forbid pairing: read after
// write, FP load half/target clashes (checked in both orders), and carry
// set/use. Combinational. Assumes register indices of one instruction all
// name the file selected by its fp flag.
module pair_hazard_check
    import pair_pkg::*;
#(
    parameter int RW = 5
) (
    input  iclass_e       cls_a,
    input  iclass_e       cls_b,
    input  iflags_t       fl_a,
    input  iflags_t       fl_b,
    input  logic [RW-1:0] rs1_a,
    input  logic [RW-1:0] rs2_a,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rs1_b,
    input  logic [RW-1:0] rs2_b,
    input  logic [RW-1:0] rd_b,
    input  logic [1:0]    rv_a,
    input  logic [1:0]    rv_b,
    input  logic          rdv_a,
    input  logic          rdv_b,
    output logic          hazard
);

    localparam int NSLOT = 2;

    iclass_e       cls_s [NSLOT];
    iflags_t       fl_s  [NSLOT];
    logic [RW-1:0] rs1_s [NSLOT];
    logic [RW-1:0] rs2_s [NSLOT];
    logic [RW-1:0] rd_s  [NSLOT];
    logic [1:0]    rv_s  [NSLOT];
    logic          rdv_s [NSLOT];
    logic [NSLOT-1:0] fp_clash;
    logic raw;
    logic fp_store_ok;
    logic carry;

    // Gather both slots into arrays so each ordering can be indexed.
    always_comb begin
        cls_s[0] = cls_a;  cls_s[1] = cls_b;
        fl_s[0]  = fl_a;   fl_s[1]  = fl_b;
        rs1_s[0] = rs1_a;  rs1_s[1] = rs1_b;
        rs2_s[0] = rs2_a;  rs2_s[1] = rs2_b;
        rd_s[0]  = rd_a;   rd_s[1]  = rd_b;
        rv_s[0]  = rv_a;   rv_s[1]  = rv_b;
        rdv_s[0] = rdv_a;  rdv_s[1] = rdv_b;
    end

    // One checker per ordering: slot X is the FP load, slot Y the FP op.
    for (genvar o = 0; o < NSLOT; o++) begin : g_order
        localparam int X = o;
        localparam int Y = NSLOT - 1 - o;
        logic x_fp_load;
        logic y_fp_op;
        logic same_tgt;
        logic touches;
        logic other_word;

        // Detect a load/op clash on target or on the unwritten word.
        always_comb begin
            x_fp_load  = (cls_s[X] == CL_LDST) && fl_s[X].fp && !fl_s[X].store && rdv_s[X];
            y_fp_op    = (cls_s[Y] == CL_FLOP) && fl_s[Y].fp;
            same_tgt   = rdv_s[Y] && (rd_s[Y] == rd_s[X]);
            touches    = same_tgt
                       || (rv_s[Y][0] && (rs1_s[Y] == rd_s[X]))
                       || (rv_s[Y][1] && (rs2_s[Y] == rd_s[X]));
            other_word = fl_s[X].wsingle && (!fl_s[Y].wsingle || (fl_s[Y].whi != fl_s[X].whi));
            fp_clash[o] = x_fp_load && y_fp_op && (same_tgt || (touches && other_word));
        end
    end

    // Read-after-write across the pair, waived for FP op then FP store.
    always_comb begin
        fp_store_ok = (cls_a == CL_FLOP) && (cls_b == CL_LDST) && fl_b.fp && fl_b.store;
        raw = rdv_a && (fl_a.fp == fl_b.fp)
            && ((rv_b[0] && (rs1_b == rd_a)) || (rv_b[1] && (rs2_b == rd_a)))
            && !fp_store_ok;
    end

    // Carry/borrow producer and consumer must not share a cycle.
    always_comb begin
        carry  = (fl_a.cset && fl_b.cuse) || (fl_b.cset && fl_a.cuse);
        hazard = raw || carry || (|fp_clash);
    end

endmodule

// File: rtl/pair_context_gate.sv
// Module: pair_context_gate
// Blocks pairing from control-flow context of the older slot: empty slots,
// delay-slot position, and odd-word taken-branch targets. Combinational.
module pair_context_gate (
    input  logic a_vld,
    input  logic b_vld,
    input  logic a_dly,
    input  logic a_tgt,
    input  logic a_waddr_lo,
    output logic ctx_ok
);

    // Both slots occupied and no positional restriction on the older one.
    always_comb begin
        ctx_ok = a_vld && b_vld && !a_dly && !(a_tgt && a_waddr_lo);
    end

endmodule

// File: rtl/dual_issue_pair_check.sv
// Module: dual_issue_pair_check (top)
// Registers the pairing decision for two adjacent pre-decoded instructions
// and the capable-ALU steering bit. Assumes the surrounding sequencer shifts
// slot B into slot A when no bundle is granted. Synchronous active-low reset.
module dual_issue_pair_check
    import pair_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic [CLS_W-1:0]  a_cls,
    input  logic [RW-1:0]     a_rs1,
    input  logic [RW-1:0]     a_rs2,
    input  logic [RW-1:0]     a_rd,
    input  logic [1:0]        a_rv,
    input  logic              a_rdv,
    input  logic [FLAG_W-1:0] a_flags,
    input  logic              a_dly,
    input  logic              a_tgt,
    input  logic              a_waddr_lo,
    input  logic              b_vld,
    input  logic [CLS_W-1:0]  b_cls,
    input  logic [RW-1:0]     b_rs1,
    input  logic [RW-1:0]     b_rs2,
    input  logic [RW-1:0]     b_rd,
    input  logic [1:0]        b_rv,
    input  logic              b_rdv,
    input  logic [FLAG_W-1:0] b_flags,
    output logic              bundle_o,
    output logic              steer_o
);

    iclass_e cls_a;
    iclass_e cls_b;
    iflags_t fl_a;
    iflags_t fl_b;
    logic    class_ok;
    logic    cap_b;
    logic    hazard;
    logic    ctx_ok;
    logic    pair_ok;

    // Reinterpret raw port fields as typed class and flag values.
    always_comb begin
        cls_a = iclass_e'(a_cls);
        cls_b = iclass_e'(b_cls);
        fl_a  = iflags_t'(a_flags);
        fl_b  = iflags_t'(b_flags);
    end

    pair_class_matrix u_matrix (
        .cls_a    (cls_a),
        .cls_b    (cls_b),
        .fl_a     (fl_a),
        .fl_b     (fl_b),
        .class_ok (class_ok),
        .cap_b    (cap_b)
    );

    pair_hazard_check #(.RW(RW)) u_hazard (
        .cls_a  (cls_a),
        .cls_b  (cls_b),
        .fl_a   (fl_a),
        .fl_b   (fl_b),
        .rs1_a  (a_rs1),
        .rs2_a  (a_rs2),
        .rd_a   (a_rd),
        .rs1_b  (b_rs1),
        .rs2_b  (b_rs2),
        .rd_b   (b_rd),
        .rv_a   (a_rv),
        .rv_b   (b_rv),
        .rdv_a  (a_rdv),
        .rdv_b  (b_rdv),
        .hazard (hazard)
    );

    pair_context_gate u_ctx (
        .a_vld      (a_vld),
        .b_vld      (b_vld),
        .a_dly      (a_dly),
        .a_tgt      (a_tgt),
        .a_waddr_lo (a_waddr_lo),
        .ctx_ok     (ctx_ok)
    );

    // Combine the three verdicts into the final pairing decision.
    always_comb begin
        pair_ok = class_ok && !hazard && ctx_ok;
    end

    // Register decision and steering; reset clears to single issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bundle_o <= 1'b0;
            steer_o  <= 1'b0;
        end else begin
            bundle_o <= pair_ok;
            steer_o  <= pair_ok && cap_b;
        end
    end

    // R1: reset leaves both outputs cleared after the edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!bundle_o && !steer_o));

    // R4: a system control instruction in either slot never bundles.
    p_sys_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cls == 4'd8 || b_cls == 4'd8) |=> !bundle_o);

    // R5: an empty slot forbids a bundle.
    p_valid_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_vld && b_vld) |=> !bundle_o);

    // R8: carry producer with carry consumer never bundles.
    p_carry_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_flags[4] && b_flags[5]) || (b_flags[4] && a_flags[5])) |=> !bundle_o);

    // R9: delay-slot older instruction never bundles.
    p_delay_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_dly || (a_tgt && a_waddr_lo)) |=> !bundle_o);

    // R12: steering to slot B only happens inside a bundle.
    p_steer_in_bundle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        steer_o |-> bundle_o);

endmodule

// File: tb/tb_dual_issue_pair_check.sv
`timescale 1ns/1ps
module tb_dual_issue_pair_check;

    localparam int RW = 5;

    typedef struct {
        bit v;
        int cls;
        int rs1, rs2, rd;
        bit r1v, r2v, rdv;
        bit fp, st, ws, wh, cs, cu, nl;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_vld, a_rdv, a_dly, a_tgt, a_waddr_lo, b_vld, b_rdv;
    logic [3:0] a_cls, b_cls;
    logic [RW-1:0] a_rs1, a_rs2, a_rd, b_rs1, b_rs2, b_rd;
    logic [1:0] a_rv, b_rv;
    logic [6:0] a_flags, b_flags;
    logic bundle_o, steer_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit pend = 0;
    bit exp_b_q, exp_s_q;
    string tag_q;

    always #10 clk = ~clk;

    dual_issue_pair_check #(.RW(RW)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_cls(a_cls), .a_rs1(a_rs1), .a_rs2(a_rs2), .a_rd(a_rd),
        .a_rv(a_rv), .a_rdv(a_rdv), .a_flags(a_flags), .a_dly(a_dly), .a_tgt(a_tgt),
        .a_waddr_lo(a_waddr_lo),
        .b_vld(b_vld), .b_cls(b_cls), .b_rs1(b_rs1), .b_rs2(b_rs2), .b_rd(b_rd),
        .b_rv(b_rv), .b_rdv(b_rdv), .b_flags(b_flags),
        .bundle_o(bundle_o), .steer_o(steer_o)
    );

    function automatic ins_t plain(int c);
        ins_t i;
        i = '{v:1, cls:c, rs1:0, rs2:0, rd:0, r1v:0, r2v:0, rdv:0,
              fp:0, st:0, ws:0, wh:0, cs:0, cu:0, nl:0};
        return i;
    endfunction

    // Reference: allowed successor classes per first class (R3).
    function automatic bit allowed(int f, int s);
        case (f)
            0: return s inside {1, 2, 3, 4, 5, 6};
            1: return s inside {0, 2, 3, 4, 6};
            2: return s inside {0, 1, 2, 3, 4, 6, 7};
            3: return s inside {0, 1, 2, 7};
            4: return s == 0;
            default: return 0;
        endcase
    endfunction

    function automatic bit cap(ins_t i);
        return i.cls == 3 || i.cls == 4 || (i.cls == 1 && !i.fp);
    endfunction

    function automatic bit reads(ins_t i, int r);
        return (i.r1v && i.rs1 == r) || (i.r2v && i.rs2 == r);
    endfunction

    function automatic bit fp_clash(ins_t ld, ins_t op);
        bit same;
        if (!(ld.cls == 1 && ld.fp && !ld.st && ld.rdv)) return 0;
        if (!(op.cls == 0 && op.fp)) return 0;
        same = op.rdv && op.rd == ld.rd;
        if (same) return 1;
        if (!reads(op, ld.rd)) return 0;
        return ld.ws && (!op.ws || op.wh != ld.wh);
    endfunction

    function automatic bit exp_bundle(ins_t a, ins_t b, bit dly, bit tgt, bit odd);
        if (!a.v || !b.v) return 0;
        if (dly || (tgt && odd)) return 0;
        if (!allowed(a.cls, b.cls)) return 0;
        if (a.nl && b.cls != 0) return 0;
        if (cap(a) && cap(b)) return 0;
        if (a.cls == 1 && b.cls == 1) return 0;
        if ((a.cs && b.cu) || (b.cs && a.cu)) return 0;
        if (a.rdv && a.fp == b.fp && reads(b, a.rd)
            && !(a.cls == 0 && b.cls == 1 && b.fp && b.st)) return 0;
        if (fp_clash(a, b) || fp_clash(b, a)) return 0;
        return 1;
    endfunction

    task automatic chk(string tag, logic act, bit exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(ins_t a, ins_t b, bit dly, bit tgt, bit odd);
        a_vld = a.v; a_cls = 4'(a.cls);
        a_rs1 = RW'(a.rs1); a_rs2 = RW'(a.rs2); a_rd = RW'(a.rd);
        a_rv = {a.r2v, a.r1v}; a_rdv = a.rdv;
        a_flags = {a.nl, a.cu, a.cs, a.wh, a.ws, a.st, a.fp};
        b_vld = b.v; b_cls = 4'(b.cls);
        b_rs1 = RW'(b.rs1); b_rs2 = RW'(b.rs2); b_rd = RW'(b.rd);
        b_rv = {b.r2v, b.r1v}; b_rdv = b.rdv;
        b_flags = {b.nl, b.cu, b.cs, b.wh, b.ws, b.st, b.fp};
        a_dly = dly; a_tgt = tgt; a_waddr_lo = odd;
    endtask

    // One clock: check the previous pair's result, then present a new pair.
    task automatic apply(ins_t a, ins_t b, bit dly, bit tgt, bit odd, string tag);
        @(negedge clk);
        if (pend) begin
            chk(tag_q, bundle_o, exp_b_q, "bundle");
            chk(tag_q, steer_o, exp_s_q, "steer");
        end
        drive(a, b, dly, tgt, odd);
        exp_b_q = exp_bundle(a, b, dly, tgt, odd);
        exp_s_q = exp_b_q && cap(b);
        tag_q = tag;
        pend = 1;
    endtask

    function automatic ins_t rnd_ins();
        ins_t i;
        i.v = ($urandom_range(0, 15) != 0);
        i.cls = $urandom_range(0, 8);
        i.rs1 = $urandom_range(0, 3); i.rs2 = $urandom_range(0, 3); i.rd = $urandom_range(0, 3);
        i.r1v = $urandom_range(0, 1); i.r2v = $urandom_range(0, 1); i.rdv = $urandom_range(0, 1);
        i.fp = $urandom_range(0, 1); i.st = $urandom_range(0, 1);
        i.ws = $urandom_range(0, 1); i.wh = $urandom_range(0, 1);
        i.cs = ($urandom_range(0, 5) == 0); i.cu = ($urandom_range(0, 5) == 0);
        i.nl = ($urandom_range(0, 7) == 0);
        return i;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        ins_t a, b;
        // R1: reset holds outputs clear even with a bundle-worthy pair.
        drive(plain(2), plain(2), 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1", bundle_o, 0, "bundle in reset");
        chk("R1", steer_o, 0, "steer in reset");
        rst_n = 1'b1;

        // R3: full class sweep with neutral operands (also R4, R11 rows).
        for (int f = 0; f < 9; f++)
            for (int s = 0; s < 9; s++)
                apply(plain(f), plain(s), 0, 0, 0, "R3");

        apply(plain(8), plain(2), 0, 0, 0, "R4");
        apply(plain(2), plain(8), 0, 0, 0, "R4");
        a = plain(2); b = plain(2); b.v = 0;
        apply(a, b, 0, 0, 0, "R5");
        a.v = 0; b.v = 1;
        apply(a, b, 0, 0, 0, "R5");

        // R6: integer RAW refused; FP op to FP store allowed; cross-file allowed.
        a = plain(2); a.rdv = 1; a.rd = 3; b = plain(2); b.r2v = 1; b.rs2 = 3;
        apply(a, b, 0, 0, 0, "R6");
        a = plain(0); a.fp = 1; a.rdv = 1; a.rd = 2;
        b = plain(1); b.fp = 1; b.st = 1; b.r2v = 1; b.rs2 = 2;
        apply(a, b, 0, 0, 0, "R6");
        a = plain(2); a.rdv = 1; a.rd = 3; b = plain(0); b.fp = 1; b.r1v = 1; b.rs1 = 3;
        apply(a, b, 0, 0, 0, "R6");

        // R7: op reads other word of load target; same word; same target.
        a = plain(0); a.fp = 1; a.r1v = 1; a.rs1 = 4; a.ws = 1; a.wh = 1;
        b = plain(1); b.fp = 1; b.rdv = 1; b.rd = 4; b.ws = 1; b.wh = 0;
        apply(a, b, 0, 0, 0, "R7");
        a.wh = 0;
        apply(a, b, 0, 0, 0, "R7");
        a = plain(0); a.fp = 1; a.rdv = 1; a.rd = 5;
        b = plain(1); b.fp = 1; b.rdv = 1; b.rd = 5;
        apply(a, b, 0, 0, 0, "R7");

        // R8: carry producer/consumer in both orders.
        a = plain(2); a.cs = 1; b = plain(2); b.cu = 1;
        apply(a, b, 0, 0, 0, "R8");
        a = plain(2); a.cu = 1; b = plain(2); b.cs = 1;
        apply(a, b, 0, 0, 0, "R8");

        // R9: delay slot, odd and even taken target.
        apply(plain(2), plain(2), 1, 0, 0, "R9");
        apply(plain(2), plain(2), 0, 1, 1, "R9");
        apply(plain(2), plain(2), 0, 1, 0, "R9");

        // R10: nullify-capable older op pairs only with an FP op.
        a = plain(2); a.nl = 1;
        apply(a, plain(2), 0, 0, 0, "R10");
        apply(a, plain(0), 0, 0, 0, "R10");

        // R11: capable ALU sharing and load/store pairs.
        apply(plain(1), plain(3), 0, 0, 0, "R11");
        a = plain(1); a.fp = 1;
        apply(a, plain(3), 0, 0, 0, "R11");
        b = plain(1); b.fp = 1;
        apply(a, b, 0, 0, 0, "R11");

        // R12: steering follows the younger capable op.
        apply(plain(2), plain(3), 0, 0, 0, "R12");
        apply(plain(3), plain(2), 0, 0, 0, "R12");

        // R2: random pairs compared each clock against the one-edge latency.
        for (int n = 0; n < 3000; n++)
            apply(rnd_ins(), rnd_ins(), ($urandom_range(0, 9) == 0),
                  $urandom_range(0, 1), $urandom_range(0, 1), "R2");

        apply(plain(0), plain(0), 0, 0, 0, "R3");
        @(negedge clk);
        chk(tag_q, bundle_o, exp_b_q, "bundle");
        chk(tag_q, steer_o, exp_s_q, "steer");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule